// File: doc/BRIEF.md
# Fractional Clock Divider With Triggered Commit

This block divides a reference clock-enable stream by a programmable ratio that has both an integer and a fractional part. It produces a one-cycle enable pulse in the source clock domain, not a new clock. The ratio is held in a 32-bit control register as a fixed-point field with `FRAC_W` fraction bits, at a configurable bit offset. The field stores the divisor minus one, so the scaled divisor is the field value plus `2**FRAC_W`.

Software stages a new field value and then writes the trigger bit. The staged value becomes the active divisor only at an output pulse boundary, and only while the gate input is open. The trigger bit reads back as 1 until that happens and then clears by itself. A fixed variant, selected by a parameter, ties the divisor to a constant and ignores every write to the field.

Division uses a phase accumulator. On each enabled reference cycle it adds `2**FRAC_W`. When the sum reaches the scaled divisor it emits a pulse and keeps the remainder.

Top module: `frac_clk_div`

## Requirements
- R1: With a field of 0 the divisor is exactly 1.0, and every enabled reference cycle (ref_en and gate_open both high) yields one output pulse.
- R2: The scaled divisor is D = field + 2**FRAC_W. Each enabled cycle adds 2**FRAC_W to an accumulator, and a pulse is emitted, with D subtracted, whenever the sum is at least D. With FRAC_W=2 and field 7, 11 enabled cycles starting from a zero accumulator yield exactly 4 pulses.
- R3: The all-ones field gives the largest divisor, (2**FIELD_W - 1) + 2**FRAC_W. With FIELD_W=6 and FRAC_W=2 that is 67, so 67 enabled cycles give exactly 4 pulses.
- R4: The field occupies bits [FIELD_SHIFT+FIELD_W-1:FIELD_SHIFT] of the register. A field-only write (fld_wr) replaces just those bits and leaves every other bit unchanged. A full write (reg_wr) stores all bits except the trigger bit, and reg_wr takes priority when both writes occur in the same cycle.
- R5: A full write with bit TRIG_BIT set makes trig_busy high from the next cycle, and reg_rdata[TRIG_BIT] shows trig_busy. Writing the field alone never changes the active divisor.
- R6: A pending trigger commits the current register field at the clock edge that produces an output pulse. trig_busy falls in the same cycle that pulse appears, and the new divisor applies from the next enabled cycle on.
- R7: When gate_open or ref_en is low, the accumulator holds, no pulse is produced, and a pending trigger stays pending until the gate opens.
- R8: In the fixed variant (FIXED=1) the divisor is always FIXED_FIELD + 2**FRAC_W, the field reads back as FIXED_FIELD, and writes to it have no effect.
- R9: After reset the register reads RESET_FIELD at the field position and zero elsewhere, trig_busy is low, no pulse is output, and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference enable stream to be divided |
| gate_open | input | 1 | High while the divided clock is ungated |
| reg_wr | input | 1 | Full register write strobe |
| reg_wdata | input | 32 | Full register write data; bit TRIG_BIT requests a commit |
| fld_wr | input | 1 | Field-only write strobe |
| fld_val | input | FIELD_W | New divisor field value (divisor minus one, fixed point) |
| reg_rdata | output | 32 | Register readback, with trig_busy at TRIG_BIT |
| trig_busy | output | 1 | A commit is pending |
| div_pulse | output | 1 | Divided one-cycle enable pulse |

## Verification
The assertions check four properties on every cycle:
- a trigger write raises the busy flag;
- busy only falls together with an output pulse;
- a closed gate suppresses pulses and keeps a pending trigger pending;
- a field-only write disturbs no other register bit, and a fixed variant always reads its constant.

Some properties depend on the accumulator's arithmetic, which only the bench's reference model and counted pulse windows can show. These are the exact pulse counts for a given fractional ratio, that a staged field stays inactive until committed, and that the committed ratio takes effect from the following cycle.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   // Scaled divisor represented by a stored field: field plus one whole unit.
   function automatic int unsigned scaled_of(input int unsigned field, input int unsigned frac_w);
      return field + (32'd1 << frac_w);
   endfunction

   // Mask covering a field inside a 32-bit register word.
   function automatic logic [31:0] field_mask(input int unsigned shift, input int unsigned width);
      return ((32'd1 << width) - 32'd1) << shift;
   endfunction
endpackage

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
   parameter int FRAC_W  = 2,
   parameter int FIELD_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic [FIELD_W-1:0] field,
   output logic               hit,
   output logic               pulse
);
   localparam int ACC_W = FIELD_W + 2;
   localparam logic [ACC_W-1:0] UNIT = ACC_W'(frac_div_pkg::scaled_of(0, FRAC_W));

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] div_v;
   logic [ACC_W-1:0] sum_v;

   assign div_v = ACC_W'(field) + UNIT;
   assign sum_v = acc_q + UNIT;
   assign hit   = step && (sum_v >= div_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= hit;
         if (step) acc_q <= hit ? (sum_v - div_v) : sum_v;
      end
   end
endmodule

// File: rtl/frac_div_cfg.sv
module frac_div_cfg #(
   parameter int FIELD_W     = 6,
   parameter int FIELD_SHIFT = 8,
   parameter int TRIG_BIT    = 1,
   parameter bit FIXED       = 1'b0,
   parameter int FIXED_FIELD = 5,
   parameter int RESET_FIELD = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   input  logic               fld_wr,
   input  logic [FIELD_W-1:0] fld_val,
   input  logic               commit,
   output logic [31:0]        reg_rdata,
   output logic               busy,
   output logic [FIELD_W-1:0] active_field
);
   localparam logic [31:0] FMASK = frac_div_pkg::field_mask(FIELD_SHIFT, FIELD_W);
   localparam logic [31:0] TMASK = 32'd1 << TRIG_BIT;
   localparam int          INIT_FIELD = FIXED ? FIXED_FIELD : RESET_FIELD;

   logic [31:0] reg_q;
   logic [31:0] reg_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= 32'(INIT_FIELD) << FIELD_SHIFT;
         busy  <= 1'b0;
      end else begin
         busy <= (reg_wr && reg_wdata[TRIG_BIT]) || (busy && !commit);
         if (reg_wr)      reg_q <= reg_wdata & ~TMASK;
         else if (fld_wr) reg_q <= (reg_q & ~FMASK) | (32'(fld_val) << FIELD_SHIFT);
      end
   end

   if (FIXED) begin : g_fixed
      assign reg_view     = (reg_q & ~FMASK) | (32'(FIXED_FIELD) << FIELD_SHIFT);
      assign active_field = FIELD_W'(FIXED_FIELD);
   end else begin : g_prog
      logic [FIELD_W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      act_q <= FIELD_W'(RESET_FIELD);
         else if (commit) act_q <= reg_q[FIELD_SHIFT +: FIELD_W];
      end
      assign reg_view     = reg_q;
      assign active_field = act_q;
   end

   assign reg_rdata = reg_view | (busy ? TMASK : 32'd0);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int FRAC_W      = 2,
   parameter int FIELD_W     = 6,
   parameter int FIELD_SHIFT = 8,
   parameter int TRIG_BIT    = 1,
   parameter bit FIXED       = 1'b0,
   parameter int FIXED_FIELD = 5,
   parameter int RESET_FIELD = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_en,
   input  logic               gate_open,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   input  logic               fld_wr,
   input  logic [FIELD_W-1:0] fld_val,
   output logic [31:0]        reg_rdata,
   output logic               trig_busy,
   output logic               div_pulse
);
   if (FIELD_SHIFT + FIELD_W > 32) begin : g_err_span
      $error("divider field does not fit in the 32-bit register");
   end
   if (TRIG_BIT >= FIELD_SHIFT && TRIG_BIT < FIELD_SHIFT + FIELD_W) begin : g_err_trig
      $error("trigger bit overlaps the divider field");
   end
   if (FRAC_W < 0 || FRAC_W > FIELD_W) begin : g_err_frac
      $error("fraction width must lie within the field width");
   end
   if (FIXED_FIELD >= (1 << FIELD_W) || RESET_FIELD >= (1 << FIELD_W)) begin : g_err_val
      $error("constant field value does not fit the field width");
   end

   logic               step;
   logic               hit;
   logic               commit;
   logic [FIELD_W-1:0] active_field;

   assign step   = ref_en && gate_open;
   assign commit = trig_busy && hit;

   frac_div_cfg #(
      .FIELD_W(FIELD_W), .FIELD_SHIFT(FIELD_SHIFT), .TRIG_BIT(TRIG_BIT),
      .FIXED(FIXED), .FIXED_FIELD(FIXED_FIELD), .RESET_FIELD(RESET_FIELD)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .fld_wr(fld_wr), .fld_val(fld_val), .commit(commit),
      .reg_rdata(reg_rdata), .busy(trig_busy), .active_field(active_field)
   );

   frac_div_accum #(.FRAC_W(FRAC_W), .FIELD_W(FIELD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .step(step), .field(active_field),
      .hit(hit), .pulse(div_pulse)
   );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
   parameter int FIELD_W     = 6,
   parameter int FIELD_SHIFT = 8,
   parameter int TRIG_BIT    = 1,
   parameter bit FIXED       = 1'b0,
   parameter int FIXED_FIELD = 5
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ref_en,
   input logic        gate_open,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic        fld_wr,
   input logic [31:0] reg_rdata,
   input logic        trig_busy,
   input logic        div_pulse
);
   localparam logic [31:0] KEEP = ~(frac_div_pkg::field_mask(FIELD_SHIFT, FIELD_W) | (32'd1 << TRIG_BIT));

   AST_TRIG_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[TRIG_BIT]) |=> trig_busy); // R5

   AST_CLEAR_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trig_busy) |-> div_pulse); // R6

   AST_GATED_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_en && gate_open) |=> !div_pulse); // R7

   AST_GATED_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_busy && !gate_open) |=> trig_busy); // R7

   AST_FIELD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_wr && !reg_wr) |=> $stable(reg_rdata & KEEP)); // R4

   if (FIXED) begin : g_fix
      AST_FIXED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[FIELD_SHIFT +: FIELD_W] == FIELD_W'(FIXED_FIELD)); // R8
   end
endmodule

bind frac_clk_div frac_clk_div_chk #(
   .FIELD_W(FIELD_W), .FIELD_SHIFT(FIELD_SHIFT), .TRIG_BIT(TRIG_BIT),
   .FIXED(FIXED), .FIXED_FIELD(FIXED_FIELD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .gate_open(gate_open),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .fld_wr(fld_wr),
   .reg_rdata(reg_rdata), .trig_busy(trig_busy), .div_pulse(div_pulse)
);

// File: tb/frac_clk_div_test.sv
`timescale 1ns/1ps
module frac_clk_div_test;
   localparam int FRAC_W = 2, FIELD_W = 6, SHIFT = 8, TRIG = 1;
   localparam int UNIT = 4;
   localparam int FMAX = 63;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_en = 1'b0, gate_open = 1'b0, reg_wr = 1'b0, fld_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [FIELD_W-1:0] fld_val = '0;
   logic [31:0] rd_u, rd_f;
   logic busy_u, busy_f, pul_u, pul_f;

   always #10 clk = ~clk;

   frac_clk_div #(.FRAC_W(FRAC_W), .FIELD_W(FIELD_W), .FIELD_SHIFT(SHIFT), .TRIG_BIT(TRIG),
                  .FIXED(1'b0), .FIXED_FIELD(5), .RESET_FIELD(0)) uut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .gate_open(gate_open), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .fld_wr(fld_wr), .fld_val(fld_val),
      .reg_rdata(rd_u), .trig_busy(busy_u), .div_pulse(pul_u));

   frac_clk_div #(.FRAC_W(FRAC_W), .FIELD_W(FIELD_W), .FIELD_SHIFT(SHIFT), .TRIG_BIT(TRIG),
                  .FIXED(1'b1), .FIXED_FIELD(5), .RESET_FIELD(0)) uut_fix (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .gate_open(gate_open), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .fld_wr(fld_wr), .fld_val(fld_val),
      .reg_rdata(rd_f), .trig_busy(busy_f), .div_pulse(pul_f));

   int checks = 0, errors = 0;
   int cnt_u = 0, cnt_f = 0;
   bit done = 1'b0;

   // behavioural reference model of the programmable instance
   int m_acc = 0, m_field = 0, m_sum = 0;
   bit m_busy = 1'b0, m_pulse = 1'b0, m_hit = 1'b0;
   logic [31:0] m_reg = '0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_field = 0; m_busy = 0; m_pulse = 0; m_reg = '0;
      end else begin
         m_hit = 0;
         if (ref_en && gate_open) begin
            m_sum = m_acc + UNIT;
            if (m_sum >= m_field + UNIT) begin
               m_hit = 1;
               m_acc = m_sum - (m_field + UNIT);
            end else m_acc = m_sum;
         end
         if (m_busy && m_hit) m_field = (m_reg >> SHIFT) & FMAX;
         m_busy = (reg_wr && reg_wdata[TRIG]) || (m_busy && !m_hit);
         if (reg_wr) m_reg = reg_wdata & ~(32'd1 << TRIG);
         else if (fld_wr) m_reg = (m_reg & ~(32'(FMAX) << SHIFT)) | (32'(fld_val) << SHIFT);
         m_pulse = m_hit;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2", "div_pulse", pul_u, m_pulse);
         chk("R5", "trig_busy", busy_u, m_busy);
         chk("R4", "reg_rdata", rd_u, m_reg | (32'(m_busy) << TRIG));
         chk("R8", "fixed field", rd_f[SHIFT +: FIELD_W], 5);
         if (pul_u) cnt_u++;
         if (pul_f) cnt_f++;
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic run(input int n);
      cnt_u = 0; cnt_f = 0; ref_en = 1; gate_open = 1;
      repeat (n) tick();
      ref_en = 0;
      tick();
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [15:0] lf;
      // R9: reset state
      repeat (2) tick();
      chk("R9", "reset rdata", rd_u, 0);
      chk("R9", "reset busy", busy_u, 0);
      chk("R9", "reset pulse", pul_u, 0);
      rst_n = 1; tick();

      // R1: divide by 1.0; R8: fixed 9/4 gives 4 pulses in 9 steps
      run(9);
      chk("R1", "div1 pulses", cnt_u, 9);
      chk("R8", "fixed pulses", cnt_f, 4);

      // R4: full write then field-only write
      reg_wr = 1; reg_wdata = 32'hA5A5_00F0; tick();
      reg_wr = 0; fld_wr = 1; fld_val = 7; tick();
      fld_wr = 0; tick();
      chk("R4", "field merge", rd_u, 32'hA5A5_07F0);
      chk("R8", "fixed ignores field", rd_f, 32'hA5A5_05F0);

      // R5: staged field is not active yet
      run(8);
      chk("R5", "staged inactive", cnt_u, 8);

      // R7: trigger while gated stays pending
      gate_open = 0; ref_en = 1; reg_wr = 1; reg_wdata = 32'hA5A5_07F2; tick();
      reg_wr = 0; cnt_u = 0;
      repeat (5) tick();
      chk("R7", "busy while gated", busy_u, 1);
      chk("R7", "readback trig bit", rd_u[TRIG], 1);
      chk("R7", "no pulse gated", cnt_u, 0);

      // R6: gate opens, commit coincides with a pulse
      gate_open = 1; tick();
      chk("R6", "busy cleared", busy_u, 0);
      chk("R6", "pulse at commit", pul_u, 1);
      ref_en = 0; tick();

      // R2: 11/4 ratio, 4 pulses in 11 steps
      run(11);
      chk("R2", "frac pulses", cnt_u, 4);

      // R3: maximum field 63 -> divisor 67/4
      reg_wr = 1; reg_wdata = 32'hA5A5_3FF2; tick();
      reg_wr = 0; ref_en = 1; gate_open = 1;
      for (int i = 0; i < 40 && busy_u; i++) tick();
      chk("R3", "commit reached", busy_u, 0);
      ref_en = 0; tick();
      run(67);
      chk("R3", "max div pulses", cnt_u, 4);

      // R7: gate open but no reference enable
      cnt_u = 0; ref_en = 0; gate_open = 1;
      repeat (5) tick();
      chk("R7", "idle no pulse", cnt_u, 0);

      // mixed stimulus compared against the model every cycle
      lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ref_en    = lf[0] | lf[1];
         gate_open = lf[2] | lf[3] | lf[4];
         reg_wr    = (lf[9:6] == 4'h3);
         reg_wdata = {lf, lf[7:0], 2'b00, lf[11:8], lf[5], 1'b0} ^ {30'd0, lf[10], 1'b0};
         fld_wr    = (lf[9:6] == 4'h5);
         fld_val   = FIELD_W'(lf[15:10] & 6'h0F);
         tick();
      end
      reg_wr = 0; fld_wr = 0;
      tick();
      finish_up();
   end
endmodule